// File: doc/BRIEF.md
# Reset Pin Drive-and-Sense Controller

This block owns a bidirectional, open-drain system reset line. When the chip asks for a reset, it pulls the line low for a fixed minimum time. It then lets go of the line for a short settle window and reads the level back. If something outside still holds the line low, the block pulls it low again and repeats the whole cycle. It keeps doing this until the line reads high after a window. At that point the reset sequence is over, and the block emits a one-cycle completion pulse that lets the processor start its reset handling.

After power-on the line is held low until the clock generator reports lock. It then stays low for one more full drive period before the first release-and-test. A low level forced onto the line from outside while the block is idle starts the same sequence. A master reset for the on-chip modules stays asserted for as long as any phase of the sequence is running.

The pin is modelled as an active-high output enable (the line is pulled low when it is set) plus a separate input. The input is synchronised before it is used.

Top module: `rstpin_ctrl`

## Requirements
- R1: A reset request that is already low again before the drive period ends makes `pin_oe` stay high for exactly 512 consecutive cycles.
- R2: A reset request held high for L cycles, with L above 512, makes `pin_oe` stay high for exactly L cycles. In general the drive lasts max(512, L) cycles.
- R3: Each drive period is followed by exactly 10 cycles with `pin_oe` low, before the line level is acted on.
- R4: At the end of a release window, a high line (`pin_in` = 1) ends the sequence. A low line starts another drive period. The number of drive periods is therefore one more than the number of windows that ended with the line low.
- R5: `rst_done` is high for exactly one cycle, in the cycle right after the last release cycle. In that cycle `pin_oe` and `mst_rst` are both low.
- R6: From reset until `pll_lock` is seen, `pin_oe` and `mst_rst` are high. Once `pll_lock` rises, `pin_oe` stays high for exactly 512 more cycles, and the release-and-test step follows.
- R7: `mst_rst` is high during every drive and release cycle, is low while idle, and is never high for fewer than 4 cycles.
- R8: When the block is idle, a low on `pin_in` starts a sequence. `pin_oe` goes high 3 cycles after the low appears: 2 synchroniser stages plus 1 state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| int_req | input | 1 | Internal reset request, active high |
| pll_lock | input | 1 | Clock generator lock indication |
| pin_in | input | 1 | Level read back from the reset line (1 = high) |
| pin_oe | output | 1 | Pull the reset line low when high |
| mst_rst | output | 1 | Master reset to internal modules, active high |
| rst_done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The hardest case to reach is a sequence that retries several times. It needs the outside world to hold the line low across one or more whole release windows and then let go at a known point. The bench models the line as wired-AND of `pin_oe` and an external pull-down. It keeps the pull-down active through a chosen number of drive phases and releases it at a random offset inside the last intended drive phase. The expected count of drive periods is then exact, and the release never lands on a sampling boundary. Random request lengths on both sides of 512 cover the stretch rule.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

    typedef enum logic [1:0] {
        PH_POWERUP = 2'd0,
        PH_DRIVE   = 2'd1,
        PH_RELEASE = 2'd2,
        PH_IDLE    = 2'd3
    } phase_e;

    typedef struct packed {
        logic drive;
        logic busy;
        logic done;
    } pin_ctl_t;

    function automatic logic phase_pulls_low(phase_e p);
        return (p == PH_POWERUP) || (p == PH_DRIVE);
    endfunction

    function automatic int cnt_width(int drive_cycles);
        return $clog2(drive_cycles) + 2;
    endfunction

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstpin_seq.sv
module rstpin_seq
    import rstpin_pkg::*;
#(
    parameter int DRIVE_CYCLES   = 512,
    parameter int RELEASE_CYCLES = 10,
    parameter int CNT_W          = 11
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     int_req,
    input  logic     pll_lock,
    input  logic     pin_hi,
    output pin_ctl_t ctl
);
    localparam logic [CNT_W-1:0] DRV_LOAD = CNT_W'(DRIVE_CYCLES - 1);
    localparam logic [CNT_W-1:0] REL_LOAD = CNT_W'(RELEASE_CYCLES - 1);

    phase_e            phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              done_q, done_d;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        unique case (phase_q)
            PH_POWERUP: begin
                if (pll_lock) begin
                    phase_d = PH_DRIVE;
                    cnt_d   = DRV_LOAD;
                end
            end
            PH_DRIVE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (!int_req) begin
                    phase_d = PH_RELEASE;
                    cnt_d   = REL_LOAD;
                end
            end
            PH_RELEASE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (pin_hi) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end else begin
                    phase_d = PH_DRIVE;
                    cnt_d   = DRV_LOAD;
                end
            end
            PH_IDLE: begin
                if (int_req || !pin_hi) begin
                    phase_d = PH_DRIVE;
                    cnt_d   = DRV_LOAD;
                end
            end
            default: begin
                phase_d = PH_POWERUP;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_POWERUP;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    always_comb begin
        ctl.drive = phase_pulls_low(phase_q);
        ctl.busy  = (phase_q != PH_IDLE);
        ctl.done  = done_q;
    end
endmodule

// File: rtl/rstpin_hold.sv
module rstpin_hold #(
    parameter int MIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic mst_rst
);
    localparam int HW = $clog2(MIN_CYCLES + 1);
    localparam logic [HW-1:0] HMAX = HW'(MIN_CYCLES);

    logic [HW-1:0] held_q;
    logic          short_run;

    assign short_run = (held_q != '0) && (held_q < HMAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (busy) begin
            held_q <= (held_q == HMAX) ? HMAX : held_q + 1'b1;
        end else if (short_run) begin
            held_q <= held_q + 1'b1;
        end else begin
            held_q <= '0;
        end
    end

    assign mst_rst = busy || short_run;
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
    import rstpin_pkg::*;
#(
    parameter int DRIVE_CYCLES   = 512,
    parameter int RELEASE_CYCLES = 10,
    parameter int MIN_MASTER     = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic int_req,
    input  logic pll_lock,
    input  logic pin_in,
    output logic pin_oe,
    output logic mst_rst,
    output logic rst_done
);
    localparam int CNT_W = cnt_width(DRIVE_CYCLES);

    logic     pin_hi;
    pin_ctl_t ctl;

    rstpin_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_in),
        .q  (pin_hi)
    );

    rstpin_seq #(
        .DRIVE_CYCLES  (DRIVE_CYCLES),
        .RELEASE_CYCLES(RELEASE_CYCLES),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .int_req (int_req),
        .pll_lock(pll_lock),
        .pin_hi  (pin_hi),
        .ctl     (ctl)
    );

    rstpin_hold #(
        .MIN_CYCLES(MIN_MASTER)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .busy   (ctl.busy),
        .mst_rst(mst_rst)
    );

    assign pin_oe   = ctl.drive;
    assign rst_done = ctl.done;
endmodule

// File: rtl/rstpin_ctrl_chk.sv
module rstpin_ctrl_chk #(
    parameter int DRIVE_CYCLES   = 512,
    parameter int RELEASE_CYCLES = 10,
    parameter int MIN_MASTER     = 4
) (
    input logic clk,
    input logic rst,
    input logic int_req,
    input logic pll_lock,
    input logic pin_oe,
    input logic mst_rst,
    input logic rst_done
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] drv_run, gap, mst_run;
    logic        lock_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_run   <= '0;
            gap       <= '0;
            mst_run   <= '0;
            lock_seen <= 1'b0;
        end else begin
            drv_run   <= pin_oe  ? ((drv_run == SAT) ? SAT : drv_run + 1'b1) : '0;
            gap       <= pin_oe  ? '0 : ((gap == SAT) ? SAT : gap + 1'b1);
            mst_run   <= mst_rst ? ((mst_run == SAT) ? SAT : mst_run + 1'b1) : '0;
            lock_seen <= lock_seen | pll_lock;
        end
    end

    // R1: every drive period lasts at least the minimum
    a_r1_drive_min: assert property (@(posedge clk) disable iff (rst)
        (!pin_oe && drv_run != '0) |-> drv_run >= 16'(DRIVE_CYCLES));

    // R2: request still high keeps the line pulled low
    a_r2_hold_while_req: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && int_req) |=> pin_oe);

    // R3: completion comes after exactly one release window
    a_r3_release_len: assert property (@(posedge clk) disable iff (rst)
        rst_done |-> gap == 16'(RELEASE_CYCLES));

    // R4: a retry starts only after a full release window
    a_r4_retry_after_window: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && gap != '0 && $past(mst_rst)) |-> gap == 16'(RELEASE_CYCLES));

    // R5: completion pulse is one cycle wide and seen while idle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        rst_done |=> !rst_done);
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        rst_done |-> (!pin_oe && !mst_rst));

    // R6: held in reset until lock is seen
    a_r6_powerup_hold: assert property (@(posedge clk) disable iff (rst)
        !lock_seen |-> (pin_oe && mst_rst));

    // R7: master reset covers driving and lasts the minimum
    a_r7_master_covers: assert property (@(posedge clk) disable iff (rst)
        pin_oe |-> mst_rst);
    a_r7_master_min: assert property (@(posedge clk) disable iff (rst)
        (!mst_rst && mst_run != '0) |-> mst_run >= 16'(MIN_MASTER));
endmodule

bind rstpin_ctrl rstpin_ctrl_chk #(
    .DRIVE_CYCLES  (DRIVE_CYCLES),
    .RELEASE_CYCLES(RELEASE_CYCLES),
    .MIN_MASTER    (MIN_MASTER)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .int_req (int_req),
    .pll_lock(pll_lock),
    .pin_oe  (pin_oe),
    .mst_rst (mst_rst),
    .rst_done(rst_done)
);

// File: tb/rstpin_ctrl_tb.sv
module rstpin_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DRV = 512;
    localparam int REL = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic int_req = 1'b0;
    logic pll_lock = 1'b0;
    logic ext_low = 1'b0;
    logic pin_in, pin_oe, mst_rst, rst_done;

    int vectors = 0;
    int fails = 0;
    bit mst_bad = 1'b0;

    assign pin_in = !(pin_oe || ext_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    rstpin_ctrl u_dut (
        .clk(clk), .rst(rst), .int_req(int_req), .pll_lock(pll_lock),
        .pin_in(pin_in), .pin_oe(pin_oe), .mst_rst(mst_rst), .rst_done(rst_done)
    );

    function automatic int exp_drive(int l);
        return (l > DRV) ? l : DRV;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Follows one complete sequence; counts from the next sample point.
    task automatic track(input bit wait_rise, output int lat, output int eps,
                         output int drv_first, output int drv_last,
                         output int rel_min, output int rel_max);
        int d, r;
        lat = 0; eps = 0; drv_first = -1; drv_last = -1;
        rel_min = 1 << 20; rel_max = -1;
        if (wait_rise) begin
            do begin step(); lat++; end while (!pin_oe);
        end else begin
            step();
        end
        forever begin
            d = 0;
            while (pin_oe) begin
                if (!mst_rst) mst_bad = 1'b1;
                d++; step();
            end
            eps++;
            if (drv_first < 0) drv_first = d;
            drv_last = d;
            r = 0;
            while (!pin_oe && !rst_done) begin
                if (!mst_rst) mst_bad = 1'b1;
                r++; step();
            end
            if (r < rel_min) rel_min = r;
            if (r > rel_max) rel_max = r;
            if (rst_done) break;
        end
        chk(!pin_oe && !mst_rst, "R5 idle at done", {30'd0, pin_oe, mst_rst}, 0);
        step();
        chk(!rst_done, "R5 done width", int'(rst_done), 0);
    endtask

    task automatic idle_quiet(int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (pin_oe || mst_rst || rst_done) bad++;
        end
        chk(bad == 0, "R7 idle outputs low", bad, 0);
    endtask

    task automatic run_req(int l);
        int lat, eps, df, dl, rmin, rmax;
        int_req = 1'b1;
        fork
            begin repeat (l) @(negedge clk); int_req = 1'b0; end
        join_none
        track(1'b1, lat, eps, df, dl, rmin, rmax);
        chk(lat == 1, "R1 request latency", lat, 1);
        if (l > DRV) chk(df == exp_drive(l), "R2 stretched drive", df, exp_drive(l));
        else         chk(df == exp_drive(l), "R1 minimum drive", df, exp_drive(l));
        chk(eps == 1, "R4 single pass", eps, 1);
        chk(rmin == REL && rmax == REL, "R3 release window", rmax, REL);
        idle_quiet(5);
    endtask

    task automatic run_ext(int j, int off);
        int lat, eps, df, dl, rmin, rmax;
        ext_low = 1'b1;
        fork
            begin
                @(posedge pin_oe);
                repeat (j - 1) begin @(negedge pin_oe); @(posedge pin_oe); end
                repeat (off) @(negedge clk);
                ext_low = 1'b0;
            end
        join_none
        track(1'b1, lat, eps, df, dl, rmin, rmax);
        chk(lat == 3, "R8 external trigger latency", lat, 3);
        chk(eps == j, "R4 retry count", eps, j);
        chk(rmin == REL && rmax == REL, "R3 release per retry", rmin, REL);
        chk(df == DRV && dl == DRV, "R1 retry drive length", dl, DRV);
        idle_quiet(5);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1 (sequence completion)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int lat, eps, df, dl, rmin, rmax, bad, seed;
        seed = $urandom(32'd7741);
        repeat (5) step();
        chk(pin_oe && mst_rst && !rst_done, "R6 reset state",
            {29'd0, pin_oe, mst_rst, rst_done}, 6);
        rst = 1'b0;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (!pin_oe || !mst_rst) bad++;
        end
        chk(bad == 0, "R6 hold before lock", bad, 0);

        pll_lock = 1'b1;
        track(1'b0, lat, eps, df, dl, rmin, rmax);
        chk(df == DRV, "R6 drive after lock", df, DRV);
        chk(rmax == REL, "R3 first release", rmax, REL);
        chk(eps == 1, "R4 power-on single pass", eps, 1);
        idle_quiet(8);

        run_req(1);
        run_req(700);
        run_req(512);
        run_req(513);
        for (int k = 0; k < 6; k++) run_req(1 + int'($urandom % 800));

        run_ext(1, 20);
        run_ext(2, 5);
        run_ext(3, 500);
        for (int k = 0; k < 3; k++)
            run_ext(1 + int'($urandom % 3), 5 + int'($urandom % 496));

        chk(!mst_bad, "R7 master reset during sequence", int'(mst_bad), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule